// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the 32-bit effective address for a processor whose instructions may name a memory operand. A base register value, an optional index register value scaled by a power of two, and a signed displacement are summed in a single three-input adder. The decoded instruction picks one of four address forms and one of four operation kinds. The sum is registered, so a result appears one clock after the input strobe.

Load and store kinds raise a memory-request flag alongside the address. The address-only kind returns the same sum as data for a destination register and raises no request. Addresses wrap modulo 2^32. Unaligned addresses are passed through unchanged, because no alignment rule applies. Paging and the memory access itself belong to other blocks.

Top module: `agu_ea_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid`, `mem_req` and `ea_out` are all cleared to zero at that edge.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was sampled high, and low otherwise.
- R3: Form code 00 (base + displacement) produces base + displacement. The index and scale inputs have no effect.
- R4: Form code 01 (base + index) produces base + index. The scale and displacement inputs have no effect.
- R5: Form code 10 (scaled index) produces base + (index << s), where scale code 00/01/10/11 gives s = 0/1/2/3, meaning ×1/×2/×4/×8. The displacement has no effect.
- R6: Form code 11 (full) produces base + (index << s) + displacement.
- R7: When `disp_long` is 0, the displacement is bits 7:0 of `disp`, sign-extended to 32 bits, and bits 31:8 are ignored. When `disp_long` is 1, all 32 bits of `disp` are used.
- R8: All sums wrap modulo 2^32, and no carry out is reported.
- R9: Operation code 00 (load) and 01 (store) raise `mem_req` with the result. Code 10 (address-only) and code 11 (compute-only) leave `mem_req` low but still deliver the address on `ea_out` with `out_valid`.
- R10: In a cycle after `in_valid` was low, `out_valid` and `mem_req` are low and `ea_out` keeps its previous value, whatever the other inputs held.
- R11: Addresses that are not aligned, including odd ones, are delivered unchanged with the normal request flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: the operand fields below are sampled this cycle |
| form | input | 2 | Address form code (00 base+disp, 01 base+index, 10 scaled index, 11 full) |
| op | input | 2 | Operation code (00 load, 01 store, 10 address-only, 11 compute-only) |
| disp_long | input | 1 | 1: full 32-bit displacement, 0: sign-extended low byte |
| scale | input | 2 | Index shift amount code |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| disp | input | 32 | Displacement immediate |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| mem_req | output | 1 | Result is a memory address to be accessed |
| ea_out | output | 32 | Effective address, or address-as-data for the address-only kind |

## Verification
On every cycle, the bound checker verifies the one-cycle strobe latency, the request flag against the sampled operation code, the holding of the address between strobes, and the address value against an independent model of all four forms. The bench's scenarios are needed to show specific cases. These include sign extension of short displacements at both signs, every scale code, wrap-around past 2^32, odd addresses, back-to-back strobes, and a reset arriving while a strobe is in flight.

// File: rtl/agu_pkg.sv
// agu_pkg: shared widths, code enumerations and the decoded control word
// for the effective address generator. Assumes form and op codes are 2 bits.
package agu_pkg;

    localparam int AGU_ADDR_W  = 32;
    localparam int AGU_SHORT_W = 8;
    localparam int AGU_SCALE_W = 2;

    // Address form selected by the decoded instruction
    typedef enum logic [1:0] {
        FORM_BASE_DISP = 2'b00,
        FORM_BASE_IDX  = 2'b01,
        FORM_SCALED    = 2'b10,
        FORM_FULL      = 2'b11
    } ea_form_e;

    // Operation kind that consumes the address
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_ADDR  = 2'b10,
        OP_CALC  = 2'b11
    } ea_op_e;

    // Which terms enter the adder, and whether memory is touched
    typedef struct packed {
        logic use_index;
        logic use_scale;
        logic use_disp;
        logic mem_access;
    } term_ctl_t;

endpackage

// File: rtl/agu_form_decode.sv
// agu_form_decode: turns the form and op codes into term enables and the
// memory-access flag. Purely combinational; assumes codes are fully decoded.
module agu_form_decode
    import agu_pkg::*;
(
    input  logic [1:0] form,
    input  logic [1:0] op,
    output term_ctl_t  ctl
);

    ea_form_e form_e;
    ea_op_e   op_e;

    assign form_e = ea_form_e'(form);
    assign op_e   = ea_op_e'(op);

    // Decode which of index, scale and displacement participate
    always_comb begin
        ctl = '0;
        unique case (form_e)
            FORM_BASE_DISP: begin
                ctl.use_index = 1'b0;
                ctl.use_scale = 1'b0;
                ctl.use_disp  = 1'b1;
            end
            FORM_BASE_IDX: begin
                ctl.use_index = 1'b1;
                ctl.use_scale = 1'b0;
                ctl.use_disp  = 1'b0;
            end
            FORM_SCALED: begin
                ctl.use_index = 1'b1;
                ctl.use_scale = 1'b1;
                ctl.use_disp  = 1'b0;
            end
            FORM_FULL: begin
                ctl.use_index = 1'b1;
                ctl.use_scale = 1'b1;
                ctl.use_disp  = 1'b1;
            end
            default: ctl = '0;
        endcase
        // Only load and store kinds start a memory access
        unique case (op_e)
            OP_LOAD, OP_STORE: ctl.mem_access = 1'b1;
            OP_ADDR, OP_CALC:  ctl.mem_access = 1'b0;
            default:           ctl.mem_access = 1'b0;
        endcase
    end

endmodule

// File: rtl/agu_term_shape.sv
// agu_term_shape: prepares the index and displacement adder terms. The index
// is shifted by the scale code (a mux of precomputed shifts) and forced to zero
// when unused. The displacement is either the full word or a sign-extended short
// immediate. Assumes SHORT_W < ADDR_W.
module agu_term_shape
    import agu_pkg::*;
#(
    parameter int ADDR_W  = AGU_ADDR_W,
    parameter int SHORT_W = AGU_SHORT_W,
    parameter int SCALE_W = AGU_SCALE_W
) (
    input  term_ctl_t           ctl,
    input  logic [SCALE_W-1:0]  scale,
    input  logic [ADDR_W-1:0]   index,
    input  logic [ADDR_W-1:0]   disp,
    input  logic                disp_long,
    output logic [ADDR_W-1:0]   idx_term,
    output logic [ADDR_W-1:0]   disp_term
);

    localparam int NSHIFT = 1 << SCALE_W;
    localparam int EXT_W  = ADDR_W - SHORT_W;

    logic [ADDR_W-1:0]  shifted [NSHIFT];
    logic [SCALE_W-1:0] scale_eff;
    logic [ADDR_W-1:0]  disp_short;

    // One shifted copy of the index per scale code
    for (genvar s = 0; s < NSHIFT; s++) begin : g_shift
        assign shifted[s] = index << s;
    end

    // Scale applies only in the forms that use it
    assign scale_eff = ctl.use_scale ? scale : '0;

    // Index term: chosen shift, or zero when the form has no index
    always_comb begin
        idx_term = ctl.use_index ? shifted[scale_eff] : '0;
    end

    // Short displacement sign-extended from its top bit
    assign disp_short = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};

    // Displacement term: long, short, or zero when the form has none
    always_comb begin
        if (!ctl.use_disp)
            disp_term = '0;
        else if (disp_long)
            disp_term = disp;
        else
            disp_term = disp_short;
    end

endmodule

// File: rtl/agu_adder3.sv
// agu_adder3: three-operand modulo-2^W adder. With USE_CSA the operands are
// first compressed by a 3:2 carry-save stage so only one carry chain remains;
// otherwise two chained adds are used. Both variants give identical sums.
module agu_adder3 #(
    parameter int W       = 32,
    parameter bit USE_CSA = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum
);

    if (USE_CSA) begin : g_csa
        logic [W-1:0] part_sum;
        logic [W-1:0] part_cy;
        // Bitwise 3:2 compression
        always_comb begin
            part_sum = a ^ b ^ c;
            part_cy  = (a & b) | (a & c) | (b & c);
        end
        // Final carry-propagate add; the carry out of the top bit is dropped
        assign sum = part_sum + {part_cy[W-2:0], 1'b0};
    end else begin : g_chain
        // Two chained adds, truncated to W bits
        assign sum = a + b + c;
    end

endmodule

// File: rtl/agu_ea_gen.sv
// agu_ea_gen: effective address generator top. Decodes form and op, shapes
// the index and displacement terms, sums base + index term + displacement term,
// and registers the result one cycle after in_valid. The address is held while
// no strobe arrives. Synchronous active-low reset clears all outputs.
module agu_ea_gen
    import agu_pkg::*;
#(
    parameter int ADDR_W  = AGU_ADDR_W,
    parameter int SHORT_W = AGU_SHORT_W,
    parameter int SCALE_W = AGU_SCALE_W,
    parameter bit USE_CSA = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         form,
    input  logic [1:0]         op,
    input  logic               disp_long,
    input  logic [SCALE_W-1:0] scale,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  index,
    input  logic [ADDR_W-1:0]  disp,
    output logic               out_valid,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  ea_out
);

    term_ctl_t         ctl;
    logic [ADDR_W-1:0] idx_term;
    logic [ADDR_W-1:0] disp_term;
    logic [ADDR_W-1:0] ea_sum;

    agu_form_decode u_decode (
        .form (form),
        .op   (op),
        .ctl  (ctl)
    );

    agu_term_shape #(
        .ADDR_W  (ADDR_W),
        .SHORT_W (SHORT_W),
        .SCALE_W (SCALE_W)
    ) u_shape (
        .ctl       (ctl),
        .scale     (scale),
        .index     (index),
        .disp      (disp),
        .disp_long (disp_long),
        .idx_term  (idx_term),
        .disp_term (disp_term)
    );

    agu_adder3 #(
        .W       (ADDR_W),
        .USE_CSA (USE_CSA)
    ) u_add (
        .a   (base),
        .b   (idx_term),
        .c   (disp_term),
        .sum (ea_sum)
    );

    // Output stage: flags follow the strobe, the address loads only on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            mem_req   <= 1'b0;
            ea_out    <= '0;
        end else begin
            out_valid <= in_valid;
            mem_req   <= in_valid & ctl.mem_access;
            if (in_valid)
                ea_out <= ea_sum;
        end
    end

endmodule

// File: rtl/agu_ea_gen_chk.sv
// agu_ea_gen_chk: cycle-by-cycle properties of agu_ea_gen, observed at its
// ports only, with an independent arithmetic model of the four address forms.
module agu_ea_gen_chk #(
    parameter int ADDR_W  = 32,
    parameter int SHORT_W = 8,
    parameter int SCALE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [1:0]         form,
    input logic [1:0]         op,
    input logic               disp_long,
    input logic [SCALE_W-1:0] scale,
    input logic [ADDR_W-1:0]  base,
    input logic [ADDR_W-1:0]  index,
    input logic [ADDR_W-1:0]  disp,
    input logic               out_valid,
    input logic               mem_req,
    input logic [ADDR_W-1:0]  ea_out
);

    // Reference sum for one set of operands
    function automatic logic [ADDR_W-1:0] model_ea(
        input logic [1:0]         f,
        input logic [SCALE_W-1:0] sc,
        input logic               lg,
        input logic [ADDR_W-1:0]  b,
        input logic [ADDR_W-1:0]  i,
        input logic [ADDR_W-1:0]  d
    );
        logic [ADDR_W-1:0] it;
        logic [ADDR_W-1:0] dt;
        it = '0;
        dt = '0;
        if (f == 2'b01)      it = i;
        else if (f != 2'b00) it = i << sc;
        if (f == 2'b00 || f == 2'b11)
            dt = lg ? d : {{(ADDR_W-SHORT_W){d[SHORT_W-1]}}, d[SHORT_W-1:0]};
        return b + it + dt;
    endfunction

    // R2: result strobe one cycle after an accepted input strobe
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && rst_n));

    // R9: request flag matches the memory kinds of the sampled op code
    assert_req_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mem_req == ($past(op[1]) == 1'b0)));

    // R10: no request without a result
    assert_idle_noreq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !mem_req);

    // R10: address held when no strobe was accepted
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(ea_out));

    // R3 R4 R5 R6 R7 R8: address value matches the model of the sampled form
    assert_ea_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && rst_n) |->
            (ea_out == model_ea($past(form), $past(scale), $past(disp_long),
                                $past(base), $past(index), $past(disp))));

endmodule

bind agu_ea_gen agu_ea_gen_chk #(
    .ADDR_W  (ADDR_W),
    .SHORT_W (SHORT_W),
    .SCALE_W (SCALE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .form      (form),
    .op        (op),
    .disp_long (disp_long),
    .scale     (scale),
    .base      (base),
    .index     (index),
    .disp      (disp),
    .out_valid (out_valid),
    .mem_req   (mem_req),
    .ea_out    (ea_out)
);

// File: tb/agu_ea_gen_test.sv
module agu_ea_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  form = 2'b00;
    logic [1:0]  op = 2'b00;
    logic        disp_long = 1'b0;
    logic [1:0]  scale = 2'b00;
    logic [31:0] base = '0;
    logic [31:0] index = '0;
    logic [31:0] disp = '0;
    logic        out_valid;
    logic        mem_req;
    logic [31:0] ea_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    agu_ea_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .form      (form),
        .op        (op),
        .disp_long (disp_long),
        .scale     (scale),
        .base      (base),
        .index     (index),
        .disp      (disp),
        .out_valid (out_valid),
        .mem_req   (mem_req),
        .ea_out    (ea_out)
    );

    typedef struct packed {
        logic [1:0]  f;
        logic [1:0]  o;
        logic        lg;
        logic [1:0]  sc;
        logic [31:0] b;
        logic [31:0] i;
        logic [31:0] d;
        logic [31:0] exp_ea;
        logic        exp_req;
        logic [7:0]  rq;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        // R3: base+disp, index/scale ignored
        '{2'b00, 2'b00, 1'b1, 2'b11, 32'h0000_1000, 32'h0000_FFFF, 32'h0000_0010, 32'h0000_1010, 1'b1, 8'd3},
        // R7: short negative displacement, upper bits ignored
        '{2'b00, 2'b01, 1'b0, 2'b00, 32'h0000_1000, 32'h0000_0000, 32'h1234_56F0, 32'h0000_0FF0, 1'b1, 8'd7},
        // R7: short positive displacement
        '{2'b00, 2'b00, 1'b0, 2'b00, 32'h0000_2000, 32'h0000_0000, 32'hAAAA_AA7F, 32'h0000_207F, 1'b1, 8'd7},
        // R4: base+index, scale and disp ignored
        '{2'b01, 2'b00, 1'b1, 2'b10, 32'h0000_0100, 32'h0000_0020, 32'h0000_5555, 32'h0000_0120, 1'b1, 8'd4},
        // R5: scale x1, x2, x4, x8
        '{2'b10, 2'b00, 1'b1, 2'b00, 32'h0000_1000, 32'h0000_0003, 32'h0000_0000, 32'h0000_1003, 1'b1, 8'd5},
        '{2'b10, 2'b00, 1'b1, 2'b01, 32'h0000_1000, 32'h0000_0003, 32'h0000_0000, 32'h0000_1006, 1'b1, 8'd5},
        '{2'b10, 2'b00, 1'b1, 2'b10, 32'h0000_1000, 32'h0000_0003, 32'h0000_0000, 32'h0000_100C, 1'b1, 8'd5},
        '{2'b10, 2'b00, 1'b1, 2'b11, 32'h0000_1000, 32'h0000_0003, 32'h0000_0099, 32'h0000_1018, 1'b1, 8'd5},
        // R6: full form with negative long displacement, store
        '{2'b11, 2'b01, 1'b1, 2'b10, 32'h0000_4000, 32'h0000_0005, 32'hFFFF_FFFC, 32'h0000_4010, 1'b1, 8'd6},
        // R8: wrap past 2^32, address-only kind (R9)
        '{2'b11, 2'b10, 1'b1, 2'b11, 32'hFFFF_FFF0, 32'h0000_0004, 32'h0000_0010, 32'h0000_0020, 1'b0, 8'd8},
        // R9: compute-only kind gives address without request
        '{2'b11, 2'b11, 1'b1, 2'b01, 32'h0000_0010, 32'h0000_0008, 32'h0000_0001, 32'h0000_0021, 1'b0, 8'd9},
        // R11: odd address from wrapping base+index, load request kept
        '{2'b01, 2'b00, 1'b1, 2'b00, 32'h8000_0003, 32'h8000_0000, 32'h0000_0000, 32'h0000_0003, 1'b1, 8'd11},
        // R9: address-only with short displacement -1
        '{2'b00, 2'b10, 1'b0, 2'b00, 32'h0000_0000, 32'h0000_0000, 32'h0000_00FF, 32'hFFFF_FFFF, 1'b0, 8'd9},
        // R8: shifted index overflows and wraps
        '{2'b10, 2'b01, 1'b1, 2'b11, 32'h0000_0000, 32'h2000_0001, 32'h0000_0000, 32'h0000_0008, 1'b1, 8'd8}
    };

    task automatic check(input string what, input int rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Drive one strobed operation at a falling edge
    task automatic drive(input logic [1:0] f, input logic [1:0] o, input logic lg,
                         input logic [1:0] sc, input logic [31:0] b,
                         input logic [31:0] i, input logic [31:0] d);
        form = f; op = o; disp_long = lg; scale = sc;
        base = b; index = i; disp = d; in_valid = 1'b1;
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("reset out_valid", 1, {31'b0, out_valid}, 32'd0);
        check("reset mem_req", 1, {31'b0, mem_req}, 32'd0);
        check("reset ea_out", 1, ea_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R3 R4 R5 R6 R7 R8 R9 R11
        for (int k = 0; k < NVEC; k++) begin
            drive(VECS[k].f, VECS[k].o, VECS[k].lg, VECS[k].sc, VECS[k].b, VECS[k].i, VECS[k].d);
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("vec%0d ea", k), int'(VECS[k].rq), ea_out, VECS[k].exp_ea);
            check($sformatf("vec%0d req", k), int'(VECS[k].rq), {31'b0, mem_req}, {31'b0, VECS[k].exp_req});
            check($sformatf("vec%0d valid", k), 2, {31'b0, out_valid}, 32'd1);
        end

        // R10: idle cycle holds address, flags low, despite changed inputs
        base = 32'h0000_DEAD; op = 2'b00; form = 2'b11;
        @(negedge clk);
        check("idle valid", 10, {31'b0, out_valid}, 32'd0);
        check("idle req", 10, {31'b0, mem_req}, 32'd0);
        check("idle hold ea", 10, ea_out, 32'h0000_0008);
        @(negedge clk);
        check("idle hold ea 2", 10, ea_out, 32'h0000_0008);

        // R2: back-to-back strobes, each answered next cycle
        drive(2'b00, 2'b00, 1'b1, 2'b00, 32'h0000_0100, 32'h0, 32'h4);
        @(negedge clk);
        check("b2b first ea", 2, ea_out, 32'h0000_0104);
        check("b2b first valid", 2, {31'b0, out_valid}, 32'd1);
        drive(2'b00, 2'b00, 1'b1, 2'b00, 32'h0000_0200, 32'h0, 32'h4);
        @(negedge clk);
        in_valid = 1'b0;
        check("b2b second ea", 2, ea_out, 32'h0000_0204);
        check("b2b second valid", 2, {31'b0, out_valid}, 32'd1);
        @(negedge clk);
        check("b2b drop valid", 2, {31'b0, out_valid}, 32'd0);

        // R1: reset wins over a strobe in the same cycle
        drive(2'b00, 2'b00, 1'b1, 2'b00, 32'h0000_0300, 32'h0, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("mid reset valid", 1, {31'b0, out_valid}, 32'd0);
        check("mid reset req", 1, {31'b0, mem_req}, 32'd0);
        check("mid reset ea", 1, ea_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule